// File: doc/BRIEF.md
# Checksummed Serial Digit Receiver

This block takes a four-digit display value from a two-wire serial link. One wire is a bit strobe, and the block acts on its rising edge. The other wire carries the data bit that goes with each strobe. The first strobe seen while the block is idle does one thing only: it opens an input session, and the data bit on that strobe is thrown away. After that, each 5-bit symbol arrives most significant bit first. The first four symbols fill the digit registers, starting with the most significant digit. The fifth symbol is a checksum.

A symbol is assembled in a shift register that is seeded with a single marker bit. The symbol is complete when the marker has moved up to the sixth position. If the checksum does not match, or if the gap between two strobes is too long, the session is abandoned and every digit is overwritten with an error glyph. While a session is open, the block raises an active flag so that the display driver pauses its refresh. When the session closes, for whatever reason, the block emits a one-cycle done pulse, which the display takes as a request to refresh at once.

The digits leave the block as a plain register view and have no valid/ready handshake. The link has no back-pressure either: the sender paces bits freely, and the only constraint on it is the inactivity limit.

Top module: `sdr_receiver`

## Requirements
- R1: After reset, `digits_o` is all zero, and `active_o` and `done_o` are low.
- R2: A strobe rising edge while idle raises `active_o` and is otherwise ignored. The data level on that edge has no effect on any stored digit.
- R3: Each later strobe edge shifts one data bit into the symbol, most significant bit first. A symbol holds 5 bits: bit 4 is the decimal point and bits 3..0 are the glyph code. Digit k occupies `digits_o[5k+4:5k]`.
- R4: The first symbol of a session goes to digit 3, then digit 2, then digit 1, then digit 0. Each digit updates as soon as its symbol completes, while `active_o` is still high.
- R5: The fifth symbol is a checksum. If it equals the sum of the four stored 5-bit digits, truncated to 5 bits, the received digits are kept and the session ends.
- R6: On a checksum mismatch, the session ends and all four digits become 5'h0C (glyph 0xC, decimal point clear).
- R7: If `TIMEOUT_CYC` clock cycles pass with no strobe edge while active, the session ends and all four digits become 5'h0C.
- R8: The inactivity count restarts on every strobe edge, so a frame longer than `TIMEOUT_CYC` in total still completes.
- R9: `done_o` is a single-cycle pulse that coincides with the first cycle in which `active_o` is low again, for either ending.
- R10: While idle with no session ending, `digits_o` holds its value whatever `data_i` does.
- R11: After a session ends, the next strobe edge opens a fresh session, and its data bit is again discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | Asynchronous bit strobe, acted on at its rising edge |
| data_i | input | 1 | Asynchronous serial data bit |
| digits_o | output | 20 | Four 5-bit digits; digit k at bits 5k+4..5k |
| active_o | output | 1 | High while an input session is open |
| done_o | output | 1 | One-cycle pulse when a session ends |

## Verification
The hardest case to reach from the ports is the timeout. It needs the strobe to go quiet partway through a symbol, for longer than the limit, after a series of edges that each restarted the count. The bench lowers the limit to 64 cycles and paces every bit at 8 cycles, so that a full frame of 26 edges lasts far longer than the limit and still has to succeed. It then drops the strobe after a partial symbol and waits well past the limit. A scoreboard pairs each session the driver started with the done pulse that closes it. The bench also looks at digit 3 mid-frame, to show the digits fill in order.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef enum logic {
    RX_IDLE   = 1'b0,
    RX_ACTIVE = 1'b1
  } rx_state_e;
endpackage

// File: rtl/sdr_sync.sv
module sdr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sdr_sentinel_shift.sv
module sdr_sentinel_shift #(
  parameter int SYM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             full_o
);
  logic [SYM_W:0] acc_q;
  logic [SYM_W:0] acc_nxt;
  localparam logic [SYM_W:0] SEED = (SYM_W+1)'(1);

  assign acc_nxt = {acc_q[SYM_W-1:0], bit_i};
  assign sym_o   = acc_nxt[SYM_W-1:0];
  assign full_o  = shift_i & acc_nxt[SYM_W];

  always_ff @(posedge clk) begin
    if (!rst_n)        acc_q <= SEED;
    else if (load_i)   acc_q <= SEED;
    else if (shift_i)  acc_q <= acc_nxt[SYM_W] ? SEED : acc_nxt;
  end
endmodule

// File: rtl/sdr_timeout.sv
module sdr_timeout #(
  parameter int LIMIT = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else if (cnt_q != LAST)       cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && !restart_i && (cnt_q == LAST);
endmodule

// File: rtl/sdr_receiver.sv
module sdr_receiver
  import sdr_pkg::*;
#(
  parameter int          SYM_W       = 5,
  parameter int          NUM_DIGITS  = 4,
  parameter int          TIMEOUT_CYC = 2048,
  parameter int          SYNC_STAGES = 2,
  parameter logic [4:0]  ERR_CODE    = 5'h0C
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         strobe_i,
  input  logic                         data_i,
  output logic [SYM_W*NUM_DIGITS-1:0]  digits_o,
  output logic                         active_o,
  output logic                         done_o
);
  localparam int DW = SYM_W * NUM_DIGITS;
  localparam int IW = $clog2(NUM_DIGITS + 1);

  rx_state_e        state_q;
  logic [IW-1:0]    left_q;
  logic             done_q;
  logic [SYM_W-1:0] digit_q [NUM_DIGITS];

  logic strobe_s, data_s, strobe_prev_q, strobe_edge;
  logic sym_full, tmo_hit;
  logic [SYM_W-1:0] sym_val, sum_val;

  sdr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({strobe_i, data_i}), .q_o({strobe_s, data_s})
  );

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_prev_q <= 1'b0;
    else        strobe_prev_q <= strobe_s;
  end
  assign strobe_edge = strobe_s & ~strobe_prev_q;

  sdr_sentinel_shift #(.SYM_W(SYM_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load_i(state_q == RX_IDLE && strobe_edge),
    .shift_i(state_q == RX_ACTIVE && strobe_edge),
    .bit_i(data_s), .sym_o(sym_val), .full_o(sym_full)
  );

  sdr_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n),
    .run_i(state_q == RX_ACTIVE), .restart_i(strobe_edge),
    .expired_o(tmo_hit)
  );

  always_comb begin
    sum_val = '0;
    for (int i = 0; i < NUM_DIGITS; i++) sum_val = sum_val + digit_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      left_q  <= '0;
      done_q  <= 1'b0;
      for (int i = 0; i < NUM_DIGITS; i++) digit_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        RX_IDLE: begin
          if (strobe_edge) begin
            state_q <= RX_ACTIVE;
            left_q  <= IW'(NUM_DIGITS);
          end
        end
        default: begin
          if (sym_full) begin
            if (left_q != '0) begin
              for (int i = 0; i < NUM_DIGITS; i++)
                if (IW'(i + 1) == left_q) digit_q[i] <= sym_val;
              left_q <= left_q - 1'b1;
            end else begin
              state_q <= RX_IDLE;
              done_q  <= 1'b1;
              if (sym_val != sum_val)
                for (int i = 0; i < NUM_DIGITS; i++) digit_q[i] <= SYM_W'(ERR_CODE);
            end
          end else if (tmo_hit) begin
            state_q <= RX_IDLE;
            done_q  <= 1'b1;
            for (int i = 0; i < NUM_DIGITS; i++) digit_q[i] <= SYM_W'(ERR_CODE);
          end
        end
      endcase
    end
  end

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_pack
    assign digits_o[g*SYM_W +: SYM_W] = digit_q[g];
  end

  assign active_o = (state_q == RX_ACTIVE);
  assign done_o   = done_q;
endmodule

// File: rtl/sdr_receiver_chk.sv
module sdr_receiver_chk #(
  parameter int DW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] digits_o,
  input logic          active_o,
  input logic          done_o,
  input logic          strobe_edge,
  input logic          tmo_hit
);
  // R2: a session only opens on a strobe edge
  a_r2_open_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> $past(strobe_edge));

  // R9: done is one cycle wide
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: leaving a session always pulses done
  a_r9_done_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_o) |-> done_o);

  // R9: done never overlaps an open session
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !active_o);

  // R7: an expired inactivity count closes the session
  a_r7_timeout_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && tmo_hit) |=> (!active_o && done_o));

  // R10: digits hold while idle
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && !done_o) |=> $stable(digits_o));
endmodule

bind sdr_receiver sdr_receiver_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .digits_o(digits_o), .active_o(active_o),
  .done_o(done_o), .strobe_edge(strobe_edge), .tmo_hit(tmo_hit)
);

// File: tb/tb_sdr_receiver.sv
module tb_sdr_receiver;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 64;
  localparam logic [19:0] ERR_ALL = {4{5'h0C}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe_i = 1'b0;
  logic data_i = 1'b0;
  logic [19:0] digits_o;
  logic active_o, done_o;

  int checks = 0;
  int fails = 0;
  int done_seen = 0;
  bit finished = 1'b0;
  logic [19:0] exp_q [$];
  logic done_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_receiver #(.TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .data_i(data_i),
    .digits_o(digits_o), .active_o(active_o), .done_o(done_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pairs each done pulse with the expected item
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        done_seen++;
        if (exp_q.size() == 0) check("R9 unexpected done", 32'd1, 32'd0);
        else check("R5/R6/R7 digits at done", {12'd0, digits_o}, {12'd0, exp_q.pop_front()});
        check("R9 active low at done", {31'd0, active_o}, 32'd0);
      end
      if (done_prev && done_o) check("R9 done width", 32'd2, 32'd1);
      done_prev <= done_o;
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk);
    data_i = b; strobe_i = 1'b1;
    repeat (4) @(negedge clk);
    strobe_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_sym(input logic [4:0] s);
    for (int k = 4; k >= 0; k--) send_bit(s[k]);
  endtask

  task automatic send_frame(input logic [4:0] d3, d2, d1, d0, ck,
                            input logic open_bit, input logic [19:0] expv);
    exp_q.push_back(expv);
    send_bit(open_bit);
    send_sym(d3); send_sym(d2); send_sym(d1); send_sym(d0);
    send_sym(ck);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 digits", {12'd0, digits_o}, 32'd0);
    check("R1 active", {31'd0, active_o}, 32'd0);
    check("R1 done", {31'd0, done_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 R4 R5 R8: valid frame, 26 edges spanning far more than TMO cycles
    send_frame(5'd1, 5'd2, 5'd3, 5'd4, 5'd10, 1'b0, {5'd1, 5'd2, 5'd3, 5'd4});
    // R2 R11: opening bit 1 discarded; decimal points set; checksum wraps (100 mod 32)
    send_frame(5'h19, 5'h19, 5'h19, 5'h19, 5'd4, 1'b1, {4{5'h19}});
    // R6: checksum mismatch (26 expected, 25 sent)
    send_frame(5'd5, 5'd6, 5'd7, 5'd8, 5'd25, 1'b0, ERR_ALL);
    // R11: fresh valid frame after an error
    send_frame(5'd9, 5'd0, 5'd9, 5'd0, 5'd18, 1'b1, {5'd9, 5'd0, 5'd9, 5'd0});

    // R7: timeout after a partial frame
    exp_q.push_back(ERR_ALL);
    send_bit(1'b0);
    send_sym(5'd3);
    send_bit(1'b1); send_bit(1'b0);
    check("R7 still active before limit", {31'd0, active_o}, 32'd1);
    repeat (TMO + 30) @(negedge clk);
    check("R7 session closed", {31'd0, active_o}, 32'd0);

    // R4: digit 3 filled first and mid-session; others untouched
    exp_q.push_back({5'h17, 5'd2, 5'd3, 5'd4});
    send_bit(1'b0);
    send_sym(5'h17);
    repeat (6) @(negedge clk);
    check("R4 digit3 first", {27'd0, digits_o[19:15]}, 32'h17);
    check("R4 others kept", {17'd0, digits_o[14:0]}, {17'd0, ERR_ALL[14:0]});
    check("R4 still active", {31'd0, active_o}, 32'd1);
    send_sym(5'd2); send_sym(5'd3); send_sym(5'd4);
    send_sym(5'd0);  // 0x17+9 = 0x20 -> 0
    repeat (20) @(negedge clk);

    // R10: data toggles without strobe leave digits alone
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      data_i = ~data_i;
    end
    repeat (10) @(negedge clk);
    check("R10 digits hold", {12'd0, digits_o}, {12'd0, 5'h17, 5'd2, 5'd3, 5'd4});
    check("R10 no session", {31'd0, active_o}, 32'd0);

    check("R9 all sessions closed", exp_q.size(), 32'd0);
    check("R9 done count", done_seen, 32'd6);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule